// File: doc/BRIEF.md
# Control Register Unlock Sequencer

This block owns the device control byte of a small serial memory: a two-bit watchdog period selector, a three-bit block-protect selector and two volatile enable latches. Software changes the retained fields only through a fixed three-write handshake. It first arms the write latch with 02h. It then arms the register latch with 06h. A third byte then carries the new field values and commits them. Each commit starts a busy window whose length in clock cycles is a parameter. Register writes that arrive during that window are dropped.

The same block turns the block-protect selector into an address window over a 2^ADDR_W byte array and flags any query address inside it. A protected array write attempt, reported on a separate strobe, disarms the register latch. A write-protect pin blocks every register write. Two resets are provided. The ordinary reset clears only the volatile latches and the busy window. A separate cold-start reset also returns the retained fields to factory values: watchdog bits 11 and protect bits 000.

Top module: `ctrl_reg_sequencer`

## Requirements
- R1: After both resets the read byte is 60h, with the write latch, the register latch and busy all 0.
- R2: A write of exactly 02h sets the write latch in one cycle and does not raise busy.
- R3: A write of exactly 06h sets both latches when the write latch is already 1. When the write latch is 0 it changes nothing.
- R4: With both latches set, a byte with bit 2 = 0 and bit 1 = 1 commits its fields: bits 6:5 go to the watchdog bits, bits 4:3 to protect bits 1:0, and bit 0 to protect bit 2. The same write clears the register latch and holds busy high for exactly BUSY_CYCLES cycles. The sequence 02h, 06h, 02h therefore clears all retained fields.
- R5: With both latches set, a byte with bit 2 = 1 leaves the retained fields unchanged and keeps the register latch set.
- R6: A write of exactly 00h clears the write latch. Any other byte not covered by R2 to R5 is ignored.
- R7: While the write-protect pin is 1, register writes change nothing.
- R8: Register writes made while busy is 1 change nothing.
- R9: An array write strobe to an address inside the protected window clears the register latch, and this wins over a same-cycle set. A strobe outside the window has no effect.
- R10: The protect flag follows {BP2,BP1,BP0} over the 512-byte array: 000 none; 001 180h-1FFh; 010 100h-1FFh; 011 all; 100 000h-00Fh; 101 000h-01Fh; 110 000h-03Fh; 111 000h-07Fh.
- R11: The ordinary reset alone keeps the watchdog and protect fields. The cold-start reset restores WD=11, BP=000.
- R12: The read byte is, from bit 7 down: 0, WD1, WD0, BP1, BP0, register latch, write latch, BP2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Ordinary asynchronous reset, active low |
| coldRstN | input | 1 | Cold-start asynchronous reset of retained fields, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write byte |
| wpPin | input | 1 | Write-protect pin, 1 blocks register writes |
| arrWrEn | input | 1 | Array write attempt at qAddr |
| qAddr | input | ADDR_W | Query address for the protect check |
| rdData | output | 8 | Register read byte |
| wdBits | output | 2 | Watchdog period selector |
| welOut | output | 1 | Write latch |
| protectHit | output | 1 | qAddr lies in the protected window |
| nvBusy | output | 1 | Commit in progress |

## Verification
The bench builds the block with ADDR_W=9 and PAGE_BYTES=16, which gives exactly the 512-byte window table of R10. It shortens BUSY_CYCLES to 12, so that the end of every busy window, and writes dropped inside it, occur many times in a short run. With the default count of millions of cycles, a run could never leave the first commit.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;

  localparam logic [7:0] BYTE_ARM_WEL  = 8'h02;
  localparam logic [7:0] BYTE_ARM_RWEL = 8'h06;
  localparam logic [7:0] BYTE_DISARM   = 8'h00;

  localparam logic [1:0] WD_FACTORY = 2'b11;
  localparam logic [2:0] BP_FACTORY = 3'b000;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WEL,
    OP_SET_RWEL,
    OP_CLR_WEL,
    OP_COMMIT,
    OP_HOLD
  } regOp_e;

  typedef struct packed {
    logic       commit;
    logic       clrRwel;
    logic [1:0] wdNew;
    logic [2:0] bpNew;
  } seqStrobe_t;

endpackage

// File: rtl/ctrl_reg_ctl.sv
module ctrl_reg_ctl
  import ctrl_reg_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       wpPin,
  input  logic       arrWrEn,
  input  logic       protectHit,
  output seqStrobe_t strb,
  output logic       welQ,
  output logic       rwelQ,
  output logic       nvBusy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  logic             accept;
  regOp_e           op;

  assign nvBusy = (busyCnt != '0);
  assign accept = wrEn && !wpPin && !nvBusy;

  always_comb begin
    op = OP_NONE;
    if (accept) begin
      if (rwelQ && welQ && (wrData[2:1] == 2'b01)) begin
        op = OP_COMMIT;
      end else if (rwelQ && welQ && wrData[2]) begin
        op = OP_HOLD;
      end else begin
        unique case (wrData)
          BYTE_ARM_WEL:  op = OP_SET_WEL;
          BYTE_ARM_RWEL: op = welQ ? OP_SET_RWEL : OP_NONE;
          BYTE_DISARM:   op = OP_CLR_WEL;
          default:       op = OP_NONE;
        endcase
      end
    end
  end

  always_comb begin
    strb.commit  = (op == OP_COMMIT);
    strb.clrRwel = arrWrEn && protectHit;
    strb.wdNew   = wrData[6:5];
    strb.bpNew   = {wrData[0], wrData[4:3]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      rwelQ <= 1'b0;
    end else begin
      unique case (op)
        OP_SET_WEL:  welQ <= 1'b1;
        OP_SET_RWEL: welQ <= 1'b1;
        OP_CLR_WEL:  welQ <= 1'b0;
        default:     welQ <= welQ;
      endcase
      if (strb.clrRwel || strb.commit) begin
        rwelQ <= 1'b0;
      end else if (op == OP_SET_RWEL) begin
        rwelQ <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strb.commit) begin
      busyCnt <= CNT_LOAD;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rwelQ) |-> $past(welQ)); // R3
  AST_WP_FREEZES_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wpPin) |=> $stable(welQ)); // R7
  AST_PROT_CLEARS_RWEL: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && protectHit) |=> !rwelQ); // R9
  AST_BUSY_DROPS_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (nvBusy && !(arrWrEn && protectHit)) |=> ($stable(welQ) && $stable(rwelQ))); // R8

endmodule

// File: rtl/ctrl_reg_dp.sv
module ctrl_reg_dp
  import ctrl_reg_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  seqStrobe_t        strb,
  input  logic              welQ,
  input  logic              rwelQ,
  input  logic [ADDR_W-1:0] qAddr,
  output logic [7:0]        rdData,
  output logic [1:0]        wdBits,
  output logic              protectHit
);

  localparam int LW = ADDR_W + 1;
  localparam logic [LW-1:0] ARR_BYTES = LW'(1) << ADDR_W;
  localparam logic [LW-1:0] HALF_BASE = ARR_BYTES >> 1;
  localparam logic [LW-1:0] QTR_BASE  = HALF_BASE + (ARR_BYTES >> 2);

  logic [1:0]    wdQ;
  logic [2:0]    bpQ;
  logic [LW-1:0] addrExt;
  logic [LW-1:0] lowLimit [4];

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      wdQ <= WD_FACTORY;
      bpQ <= BP_FACTORY;
    end else if (strb.commit) begin
      wdQ <= strb.wdNew;
      bpQ <= strb.bpNew;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lowLim
    assign lowLimit[g] = LW'(PAGE_BYTES) << g;
  end

  assign addrExt = {1'b0, qAddr};

  always_comb begin
    unique case (bpQ)
      3'b000:  protectHit = 1'b0;
      3'b001:  protectHit = (addrExt >= QTR_BASE);
      3'b010:  protectHit = (addrExt >= HALF_BASE);
      3'b011:  protectHit = 1'b1;
      default: protectHit = (addrExt < lowLimit[bpQ[1:0]]);
    endcase
  end

  assign rdData = {1'b0, wdQ, bpQ[1:0], rwelQ, welQ, bpQ[2]};
  assign wdBits = wdQ;

  AST_NV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!coldRstN)
    !strb.commit |=> ($stable(wdQ) && $stable(bpQ))); // R4
  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!coldRstN)
    (bpQ == 3'b011) |-> protectHit); // R10
  AST_NO_LOCK: assert property (@(posedge clk) disable iff (!coldRstN)
    (bpQ == 3'b000) |-> !protectHit); // R10

endmodule

// File: rtl/ctrl_reg_sequencer.sv
module ctrl_reg_sequencer
  import ctrl_reg_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coldRstN,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              wpPin,
  input  logic              arrWrEn,
  input  logic [ADDR_W-1:0] qAddr,
  output logic [7:0]        rdData,
  output logic [1:0]        wdBits,
  output logic              welOut,
  output logic              protectHit,
  output logic              nvBusy
);

  seqStrobe_t strb;
  logic       welQ;
  logic       rwelQ;

  ctrl_reg_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wpPin(wpPin),
    .arrWrEn(arrWrEn), .protectHit(protectHit), .strb(strb),
    .welQ(welQ), .rwelQ(rwelQ), .nvBusy(nvBusy)
  );

  ctrl_reg_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_dp (
    .clk(clk), .coldRstN(coldRstN), .strb(strb), .welQ(welQ), .rwelQ(rwelQ),
    .qAddr(qAddr), .rdData(rdData), .wdBits(wdBits), .protectHit(protectHit)
  );

  assign welOut = welQ;

  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    strb.commit |=> (nvBusy && !rdData[2])); // R4
  AST_WEL_ARM: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    (wrEn && !wpPin && !nvBusy && wrData == 8'h02 && !(rdData[2] && welOut)) |=> welOut); // R2

endmodule

// File: tb/test_ctrl_reg_sequencer.sv
`timescale 1ns/1ps
module test_ctrl_reg_sequencer;

  localparam int ADDR_W = 9;
  localparam int BUSY   = 12;

  logic clk = 1'b0;
  logic rstN, coldRstN, wrEn, wpPin, arrWrEn;
  logic [7:0] wrData;
  logic [ADDR_W-1:0] qAddr;
  logic [7:0] rdData;
  logic [1:0] wdBits;
  logic welOut, protectHit, nvBusy;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic mWel, mRwel;
  logic [1:0] mWd;
  logic [2:0] mBp;
  int mBusy;

  always #2.5 clk = ~clk;

  ctrl_reg_sequencer #(.ADDR_W(ADDR_W), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY)) i_ctrl_reg_sequencer (
    .clk(clk), .rstN(rstN), .coldRstN(coldRstN), .wrEn(wrEn), .wrData(wrData),
    .wpPin(wpPin), .arrWrEn(arrWrEn), .qAddr(qAddr), .rdData(rdData),
    .wdBits(wdBits), .welOut(welOut), .protectHit(protectHit), .nvBusy(nvBusy)
  );

  function automatic logic expProt(logic [2:0] bp, logic [ADDR_W-1:0] a);
    case (bp)
      3'b000: return 1'b0;
      3'b001: return a >= 9'h180;
      3'b010: return a >= 9'h100;
      3'b011: return 1'b1;
      3'b100: return a <= 9'h00F;
      3'b101: return a <= 9'h01F;
      3'b110: return a <= 9'h03F;
      default: return a <= 9'h07F;
    endcase
  endfunction

  function automatic logic [7:0] expRd();
    return {1'b0, mWd, mBp[1], mBp[0], mRwel, mWel, mBp[2]};
  endfunction

  task automatic cmp(input int got, input int exp, input string what);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", what, got, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(rdData, expRd(), {tag, " rdData (R12)"});
    cmp(wdBits, mWd, {tag, " wdBits"});
    cmp(welOut, mWel, {tag, " welOut"});
    cmp(nvBusy, mBusy != 0, {tag, " nvBusy"});
    cmp(protectHit, expProt(mBp, qAddr), {tag, " protectHit (R10)"});
  endtask

  task automatic modelEdge();
    logic acc, nW, nR;
    acc = wrEn && !wpPin && (mBusy == 0);
    nW = mWel;
    nR = mRwel;
    if (mBusy > 0) mBusy--;
    if (acc) begin
      if (mRwel && mWel && wrData[2:1] == 2'b01) begin
        mWd = wrData[6:5];
        mBp = {wrData[0], wrData[4:3]};
        nR = 1'b0;
        mBusy = BUSY;
      end else if (mRwel && mWel && wrData[2]) begin
        nR = mRwel;
      end else if (wrData == 8'h02) begin
        nW = 1'b1;
      end else if (wrData == 8'h06 && mWel) begin
        nW = 1'b1;
        nR = 1'b1;
      end else if (wrData == 8'h00) begin
        nW = 1'b0;
      end
    end
    if (arrWrEn && expProt(mBp, qAddr)) nR = 1'b0;
    mWel = nW;
    mRwel = nR;
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic wp,
                      input logic arr, input logic [ADDR_W-1:0] a, input string tag);
    wrEn = w; wrData = d; wpPin = wp; arrWrEn = arr; qAddr = a;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic applyReset(input logic cold);
    wrEn = 0; arrWrEn = 0; wpPin = 0;
    rstN = 0;
    if (cold) coldRstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1; coldRstN = 1;
    mWel = 0; mRwel = 0; mBusy = 0;
    if (cold) begin mWd = 2'b11; mBp = 3'b000; end
  endtask

  task automatic waitIdle(input string tag);
    while (mBusy != 0) step(1'b1, 8'h00, 1'b0, 1'b0, 9'h000, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    wrEn = 0; wrData = 0; wpPin = 0; arrWrEn = 0; qAddr = 0;
    rstN = 0; coldRstN = 0;
    mWd = 2'b11; mBp = 3'b000;
    applyReset(1'b1);
    checkAll("R1 reset");
    cmp(rdData, 8'h60, "R1 reset byte");

    step(1, 8'h06, 0, 0, 9'h000, "R3 06h without WEL");
    step(1, 8'h02, 0, 0, 9'h000, "R2 arm WEL");
    cmp(nvBusy, 0, "R2 no busy");
    step(1, 8'h00, 1, 0, 9'h000, "R7 wp blocks 00h");
    step(1, 8'h06, 0, 0, 9'h000, "R3 arm RWEL");
    cmp(rdData, 8'h66, "R3 both latches");
    step(1, 8'h06, 0, 0, 9'h000, "R5 hold byte");
    step(1, 8'h5B, 1, 0, 9'h000, "R7 wp blocks commit");
    step(1, 8'h5B, 0, 0, 9'h07F, "R4 commit");
    cmp(rdData, 8'h5B, "R4 committed byte");
    step(1, 8'h00, 0, 0, 9'h080, "R8 write while busy");
    cmp(welOut, 1, "R8 WEL kept");
    waitIdle("R4 busy window");
    step(0, 8'h00, 0, 0, 9'h07F, "R10 bp111 top edge");
    step(0, 8'h00, 0, 0, 9'h080, "R10 bp111 outside");

    step(1, 8'h02, 0, 0, 9'h000, "R4 seq 02");
    step(1, 8'h06, 0, 0, 9'h000, "R4 seq 06");
    step(1, 8'h02, 0, 0, 9'h000, "R4 seq 02 commit");
    cmp(rdData, 8'h02, "R4 fields cleared");
    waitIdle("R4 busy");

    step(1, 8'h06, 0, 0, 9'h000, "R3 re-arm");
    step(1, 8'h0A, 0, 0, 9'h000, "R4 commit bp001");
    waitIdle("R4 busy");
    step(1, 8'h06, 0, 0, 9'h000, "R3 arm");
    step(0, 8'h00, 0, 1, 9'h17F, "R9 unprotected attempt");
    cmp(rdData[2], 1, "R9 RWEL kept");
    step(1, 8'h06, 0, 1, 9'h180, "R9 protected attempt beats set");
    cmp(rdData[2], 0, "R9 RWEL cleared");
    step(1, 8'h13, 0, 0, 9'h000, "R6 other byte ignored");
    step(1, 8'h00, 0, 0, 9'h000, "R6 clear WEL");
    step(1, 8'h06, 0, 0, 9'h000, "R6 ignored without WEL");

    applyReset(1'b0);
    checkAll("R11 warm reset");
    cmp(rdData, 8'h08, "R11 fields kept");
    applyReset(1'b1);
    checkAll("R11 cold reset");

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 9);
      case (r)
        0, 1:    d = 8'h02;
        2, 3:    d = 8'h06;
        4:       d = 8'h00;
        5, 6:    d = ($urandom_range(0, 255) & 8'hF9) | 8'h02;
        7:       d = $urandom_range(0, 255) | 8'h04;
        default: d = $urandom_range(0, 255);
      endcase
      step($urandom_range(0, 3) != 0, d, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, ADDR_W'($urandom_range(0, 511)), "R10 random");
      if ($urandom_range(0, 499) == 0) begin
        applyReset($urandom_range(0, 1) == 1);
        checkAll("R11 random reset");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule